// File: doc/BRIEF.md
# Frame-Synchronous Payload Scrambler

This block whitens a byte-serial OC-N SONET/SDH stream. It follows each byte's place in the 9-row frame. At every frame start it returns a 7-bit pseudo-random generator to a fixed state. It then XORs the generator output into every byte except the transport overhead at the head of the first row. Applying the same operation twice restores the original data. The one module therefore serves on the transmit side as the scrambler and on the receive side as the descrambler.

A frame-start strobe that comes with a valid byte marks row 0, column 0. Each row has 90*N columns: the first 3*N are transport overhead and the rest are payload. A position controller has three states:

- HUNT: no frame seen yet.
- TOH: inside the first-row overhead.
- BODY: every byte from the first payload byte of row 0 to the end of the frame.

The transitions are:

- HUNT→TOH on a strobe.
- TOH→BODY after the last first-row overhead byte.
- BODY→TOH after the last byte of row 8, which wraps the frame by itself.
- Any state→TOH on a strobe.

Every output is registered, so each result appears one cycle after its input byte.

Top module: `sonet_frame_scrambler`

## Requirements
- R1: During and just after reset, `vld_o`, `sof_o` and `data_o` are all zero.
- R2: Before the first frame start (state HUNT), valid bytes pass through unchanged with `pass_o`=1, and `row_o`/`col_o` report 0.
- R3: Each valid input byte produces exactly one output one cycle later with `vld_o`=1. A cycle with `vld_i`=0 gives `vld_o`=0 on the next cycle.
- R4: A byte with `sof_i`=1 and `vld_i`=1 is at row 0, column 0. The column rises by one per valid byte up to 90*N-1, then returns to 0 and the row rises. The row runs from 0 to 8. `row_o`/`col_o` give the position of the byte on `data_o`.
- R5: Bytes at row 0, columns 0 to 3*N-1 leave unchanged with `pass_o`=1.
- R6: Every other byte after a frame start is XORed with the generator byte, and `pass_o` is 0. The generator is 1+x^6+x^7 with seed 7'b1111111. Its output bit is the register MSB, and its bits are applied MSB-first, 8 steps per scrambled byte. The first mask is 0xFE. The generator advances only on scrambled bytes, and its byte pattern repeats every 127 scrambled bytes.
- R7: A strobe in the middle of a frame restarts the position at row 0, column 0 and reseeds the generator. `sof_o` marks that byte.
- R8: After row 8, column 90*N-1, the next valid byte starts a new frame without a strobe: position 0,0, a reseeded generator and `sof_o`=1.
- R9: `sof_i` and `data_i` have no effect while `vld_i` is 0. Position and generator both continue unchanged at the next valid byte.
- R10: Feeding the outputs into a second instance restores the original byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Frame start, qualified by vld_i |
| vld_i | input | 1 | Input byte valid |
| data_i | input | 8 | Input byte |
| vld_o | output | 1 | Output byte valid |
| sof_o | output | 1 | Output byte is row 0, column 0 of a frame |
| data_o | output | 8 | Processed byte |
| pass_o | output | 1 | Output byte was left unscrambled |
| row_o | output | 4 | Row of the output byte |
| col_o | output | $clog2(90*N) | Column of the output byte |

## Verification
The assertions assume three things:

- `sof_i` matters only when it comes with a valid byte.
- A frame start always lands on a byte.
- Inputs change only between clock edges.

The stimulus drives every input on the falling edge. In idle cycles it fills `sof_i` and `data_i` with random values, so that an ignored strobe is actually present. Frame starts with a valid byte are applied only at chosen points: the first frame, one mid-frame restart, and otherwise only the self-generated wrap.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int ROWS       = 9;
    localparam int TOH_PER_N  = 3;
    localparam int COLS_PER_N = 90;
    localparam int GEN_W      = 7;
    localparam logic [GEN_W-1:0] GEN_SEED = '1;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_TOH  = 2'd1,
        ST_BODY = 2'd2
    } fss_state_e;

    typedef struct packed {
        logic [7:0]       mask;
        logic [GEN_W-1:0] next;
    } gen_step_t;

    // Eight steps of 1 + x^6 + x^7, output bit taken from the MSB, first bit lands in mask[7].
    function automatic gen_step_t gen_advance_byte(input logic [GEN_W-1:0] cur);
        gen_step_t        r;
        logic [GEN_W-1:0] s;
        s = cur;
        r.mask = '0;
        for (int i = 0; i < 8; i++) begin
            r.mask[7-i] = s[GEN_W-1];
            s = {s[GEN_W-2:0], s[GEN_W-1] ^ s[GEN_W-2]};
        end
        r.next = s;
        return r;
    endfunction
endpackage

// File: rtl/fss_position.sv
module fss_position
    import fss_pkg::*;
#(
    parameter int N = 3,
    localparam int COLS  = COLS_PER_N * N,
    localparam int TOH   = TOH_PER_N * N,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             sof_i,
    output logic             start_o,
    output logic             scr_o,
    output logic             pass_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    fss_state_e       st_q, st_d, cur_st;
    logic [ROW_W-1:0] row_q, row_d, cur_row;
    logic [COL_W-1:0] col_q, col_d, cur_col;
    logic             start;

    // Position of the byte now on the input, and where the next one lands.
    always_comb begin
        start   = vld_i && (sof_i || (st_q != ST_HUNT && row_q == '0 && col_q == '0));
        cur_st  = start ? ST_TOH : st_q;
        cur_row = start ? '0 : row_q;
        cur_col = start ? '0 : col_q;
        st_d    = cur_st;
        row_d   = cur_row;
        col_d   = cur_col;
        unique case (cur_st)
            ST_HUNT: begin
                st_d = ST_HUNT;
            end
            ST_TOH: begin
                col_d = cur_col + COL_W'(1);
                if (cur_col == COL_W'(TOH - 1)) st_d = ST_BODY;
            end
            ST_BODY: begin
                if (cur_col == COL_W'(COLS - 1)) begin
                    col_d = '0;
                    if (cur_row == ROW_W'(ROWS - 1)) begin
                        row_d = '0;
                        st_d  = ST_TOH;
                    end else begin
                        row_d = cur_row + ROW_W'(1);
                    end
                end else begin
                    col_d = cur_col + COL_W'(1);
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            row_q <= '0;
            col_q <= '0;
        end else if (vld_i) begin
            st_q  <= st_d;
            row_q <= row_d;
            col_q <= col_d;
        end
    end

    always_comb begin
        start_o = start;
        scr_o   = vld_i && (cur_st == ST_BODY);
        pass_o  = (cur_st != ST_BODY);
        row_o   = cur_row;
        col_o   = cur_col;
    end

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        row_q < ROW_W'(ROWS)) else $error("row out of range"); // R4
    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        col_q < COL_W'(COLS)) else $error("column out of range"); // R4
    AST_TOH_IN_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TOH) |-> (row_q == '0 && col_q < COL_W'(TOH))) else $error("overhead state off row 0"); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(row_q) && $stable(col_q) && $stable(st_q))) else $error("position moved on idle"); // R9
endmodule

// File: rtl/fss_generator.sv
module fss_generator
    import fss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       advance_i,
    output logic [7:0] mask_o
);
    logic [GEN_W-1:0] gen_q, base;
    gen_step_t        step;

    always_comb begin
        base   = restart_i ? GEN_SEED : gen_q;
        step   = gen_advance_byte(base);
        mask_o = step.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      gen_q <= GEN_SEED;
        else if (restart_i || advance_i) gen_q <= advance_i ? step.next : base;
    end

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q != '0) else $error("generator locked at zero"); // R6
    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !advance_i) |=> $stable(gen_q)) else $error("generator moved while idle"); // R6
endmodule

// File: rtl/fss_xor_stage.sv
module fss_xor_stage #(
    parameter int ROW_W = 4,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             start_i,
    input  logic             scr_i,
    input  logic             pass_i,
    input  logic [7:0]       data_i,
    input  logic [7:0]       mask_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic             vld_o,
    output logic             sof_o,
    output logic [7:0]       data_o,
    output logic             pass_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            sof_o  <= 1'b0;
            data_o <= '0;
            pass_o <= 1'b0;
            row_o  <= '0;
            col_o  <= '0;
        end else begin
            vld_o <= vld_i;
            sof_o <= vld_i && start_i;
            if (vld_i) begin
                data_o <= data_i ^ (scr_i ? mask_i : 8'h00);
                pass_o <= pass_i;
                row_o  <= row_i;
                col_o  <= col_i;
            end
        end
    end
endmodule

// File: rtl/sonet_frame_scrambler.sv
module sonet_frame_scrambler
    import fss_pkg::*;
#(
    parameter int N = 3,
    localparam int COL_W = $clog2(COLS_PER_N * N),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             vld_i,
    input  logic [7:0]       data_i,
    output logic             vld_o,
    output logic             sof_o,
    output logic [7:0]       data_o,
    output logic             pass_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    logic             start, scr, pass;
    logic [7:0]       mask;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    fss_position #(.N(N)) u_position (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld_i),
        .sof_i   (sof_i),
        .start_o (start),
        .scr_o   (scr),
        .pass_o  (pass),
        .row_o   (cur_row),
        .col_o   (cur_col)
    );

    fss_generator u_generator (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start),
        .advance_i (scr),
        .mask_o    (mask)
    );

    fss_xor_stage #(.ROW_W(ROW_W), .COL_W(COL_W)) u_xor_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld_i),
        .start_i (start),
        .scr_i   (scr),
        .pass_i  (pass),
        .data_i  (data_i),
        .mask_i  (mask),
        .row_i   (cur_row),
        .col_i   (cur_col),
        .vld_o   (vld_o),
        .sof_o   (sof_o),
        .data_o  (data_o),
        .pass_o  (pass_o),
        .row_o   (row_o),
        .col_o   (col_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_o) else $error("output without input"); // R3
    AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o) else $error("input byte lost"); // R3
    AST_PASS_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && pass) |=> (data_o == $past(data_i))) else $error("unscrambled byte altered"); // R5
    AST_START_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sof_i) |=> (sof_o && pass_o && row_o == '0 && col_o == '0)) else $error("frame start misplaced"); // R4
endmodule

// File: tb/sonet_frame_scrambler_bench.sv
module sonet_frame_scrambler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 1;
    localparam int COLS  = 90 * NB;
    localparam int TOH   = 3 * NB;
    localparam int FRAME = 9 * COLS;
    localparam int COL_W = $clog2(COLS);
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_i = 1'b0, vld_i = 1'b0;
    logic [7:0] data_i = '0;
    logic vld_o, sof_o, pass_o;
    logic [7:0] data_o;
    logic [3:0] row_o;
    logic [COL_W-1:0] col_o;
    logic rx_vld, rx_sof, rx_pass;
    logic [7:0] rx_data;
    logic [3:0] rx_row;
    logic [COL_W-1:0] rx_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonet_frame_scrambler #(.N(NB)) u_sonet_frame_scrambler (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .vld_i(vld_i), .data_i(data_i),
        .vld_o(vld_o), .sof_o(sof_o), .data_o(data_o), .pass_o(pass_o),
        .row_o(row_o), .col_o(col_o));

    sonet_frame_scrambler #(.N(NB)) u_sonet_frame_scrambler_rx (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_o), .vld_i(vld_o), .data_i(data_o),
        .vld_o(rx_vld), .sof_o(rx_sof), .data_o(rx_data), .pass_o(rx_pass),
        .row_o(rx_row), .col_o(rx_col));

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit seq [127];

    // Reference model state
    bit m_hunt = 1'b1;
    int m_row = 0, m_col = 0, m_gidx = 0;
    bit ghost = 1'b0;
    bit h1_vld = 1'b0;
    logic [7:0] h1_data = '0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int idx);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[7-j] = seq[(idx + j) % 127];
        return b;
    endfunction

    task automatic step_byte(input logic s, input logic v, input logic [7:0] d);
        bit start, pass, wrap;
        logic [7:0] exp;
        int er, ec;
        @(negedge clk);
        sof_i = s; vld_i = v; data_i = d;
        start = 1'b0; pass = 1'b1; exp = d; wrap = 1'b0; er = 0; ec = 0;
        if (v) begin
            wrap  = !s && !m_hunt && m_row == 0 && m_col == 0;
            start = s || wrap;
            if (start) begin m_hunt = 1'b0; m_row = 0; m_col = 0; m_gidx = 0; end
            pass = m_hunt || (m_row == 0 && m_col < TOH);
            if (!pass) begin
                exp = d ^ gen_byte(m_gidx);
                m_gidx = (m_gidx + 8) % 127;
            end
            er = m_row; ec = m_col;
            if (!m_hunt) begin
                m_col++;
                if (m_col == COLS) begin m_col = 0; m_row = (m_row + 1) % 9; end
            end
        end
        @(posedge clk); #1;
        chk("R3", vld_o, v);
        if (v) begin
            chk(m_hunt ? "R2" : (pass ? "R5" : "R6"), data_o, exp);
            chk(pass ? "R5" : "R6", pass_o, pass);
            chk(s ? "R7" : (wrap ? "R8" : "R4"), sof_o, start);
            chk(ghost ? "R9" : "R4", row_o, er);
            chk(ghost ? "R9" : "R4", col_o, ec);
            ghost = 1'b0;
        end else if (s) begin
            ghost = 1'b1;
        end
        chk("R10", rx_vld, h1_vld);
        if (h1_vld) chk("R10", rx_data, h1_data);
        h1_vld = v; h1_data = d;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 7; i++) seq[i] = 1'b1;
        for (int i = 0; i < 120; i++) seq[i+7] = seq[i] ^ seq[i+1];

        repeat (3) @(negedge clk);
        #1;
        chk("R1", vld_o, 0); chk("R1", sof_o, 0); chk("R1", data_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", vld_o, 0); chk("R1", sof_o, 0); chk("R1", data_o, 0);

        // Hunt: bytes pass untouched
        for (int i = 0; i < 20; i++) step_byte(1'b0, 1'b1, 8'($urandom));

        // Zero payload frame: generator sequence visible, then wrap into a second frame
        step_byte(1'b1, 1'b1, 8'h00);
        for (int i = 1; i < FRAME + 300; i++) step_byte(1'b0, 1'b1, 8'h00);

        // Mid-frame restart
        step_byte(1'b1, 1'b1, 8'($urandom));
        for (int i = 0; i < 400; i++) step_byte(1'b0, 1'b1, 8'($urandom));

        // Random data with idle gaps carrying junk strobes
        for (int i = 0; i < 3 * FRAME; i++) begin
            if ($urandom % 4 == 0)
                step_byte(1'($urandom), 1'b0, 8'($urandom));
            else
                step_byte(1'b0, 1'b1, 8'($urandom));
        end

        // Restart exactly at the last byte of the overhead and at the last column
        for (int k = 0; k < 2; k++) begin
            step_byte(1'b1, 1'b1, 8'($urandom));
            for (int i = 1; i < (k == 0 ? TOH - 1 : COLS - 1); i++)
                step_byte(1'b0, 1'b1, 8'($urandom));
        end
        for (int i = 0; i < FRAME + 20; i++) step_byte(1'b0, 1'b1, 8'($urandom));
        step_byte(1'b0, 1'b0, 8'h00);
        step_byte(1'b0, 1'b0, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule